// File: doc/BRIEF.md
# Paired Output Compare Unit

This block holds two compare channels that watch one shared free-running timer count. Each channel has a compare register. When the count reaches a channel's compare value and that channel is started, the channel raises a match flag and toggles an output pin. A 16-bit control word on a small register bus sets the pairing mode, the pin levels, the flag clears, the interrupt enables and the per-channel start bits. Each channel has its own interrupt request line.

In separate mode each pin follows its own channel. In paired mode, pin 1 toggles on a match of either channel, so two compare values can mark the rising and falling edges of one pulse on pin 1. Any write to the control word also loads both pin levels, which lets software put each pin in a known state before it starts the channels.

Top module: `ocu_pair`

## Requirements
- R1: After a synchronous active-low reset, the control word reads 0xEC0C. Both compare registers read 0, and both pins and both interrupt lines are 0.
- R2: Control bits 15:13, 11:10 and 3:2 ignore writes and always read back as 1.
- R3: The bus address selects the register: 0 is the control word, 1 is compare 0 and 2 is compare 1. Compare registers read back what was written. Address 3 reads 0, and the read data is 0 while `bus_sel` is low.
- R4: A channel matches when the count presented before a clock edge equals its compare value and its start bit (bit 0 for channel 0, bit 1 for channel 1) is 1. At that edge the channel's flag (bit 6 for channel 0, bit 7 for channel 1) sets and its pin toggles.
- R5: While a channel's start bit is 0, it raises no flag and toggles no pin. Its pin keeps its last level.
- R6: With the mode bit (bit 12) at 0, pin 0 toggles only on a channel-0 match and pin 1 only on a channel-1 match.
- R7: With the mode bit at 1, pin 0 toggles only on a channel-0 match and pin 1 toggles on a match of either channel. If both channels match in the same cycle, pin 1 toggles once.
- R8: A control write drives pin 0 to bit 8 and pin 1 to bit 9 from the next clock. In that cycle the write takes priority over a toggle.
- R9: Writing 0 to a flag bit clears the flag and writing 1 leaves it unchanged. A match in the same cycle as a clear leaves the flag set.
- R10: While `bus_rmw` is 1, the flag bits read as 1.
- R11: Interrupt line i is 1 exactly when flag i and enable i are both 1. Enable bit 4 belongs to channel 0 and enable bit 5 to channel 1.
- R12: A match is taken only on entry to equality. A count held at the compare value for several clocks gives one toggle, and the count must leave the value and return before the next match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tmr_count | input | 16 | Shared free-running timer count |
| bus_sel | input | 1 | Register access in progress |
| bus_we | input | 1 | Write strobe (with bus_sel) |
| bus_rmw | input | 1 | Current read is part of a read-modify-write |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| irq | output | 2 | Interrupt request per channel |
| pin_out | output | 2 | Compare output pin levels |

## Verification
On every cycle, the assertions check the following: a match sets its flag, a flag only rises after a match, writing 1 never drops a flag, pins hold when nothing drives them, the mode routing of toggles, the priority of level writes, and the single match per equality interval. Only the bench scenarios can show the decoded values. These are the reset word, the ones in the unused bits, compare readback, the masked flag read during read-modify-write, and the exact pin levels after sequences of matches in both modes. The bench's reference model compares the pins, the interrupt lines and the read data on every clock, including in a long phase of random counts and register traffic.

// File: rtl/ocu_pair_pkg.sv
// Package: shared register addresses, control-word bit positions and a
// decoded view of the control word for the paired output compare unit.
package ocu_pair_pkg;

    localparam int NCH = 2;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CMP0 = 2'd1;

    localparam int BIT_MODE = 12;
    localparam int BIT_LVL0 = 8;
    localparam int BIT_FLG0 = 6;
    localparam int BIT_IEN0 = 4;
    localparam int BIT_RUN0 = 0;

    // Bits that read as one regardless of state.
    localparam logic [15:0] FIXED_ONES = 16'hEC0C;

    typedef struct packed {
        logic       mode;
        logic [1:0] lvl;
        logic [1:0] flg;
        logic [1:0] ien;
        logic [1:0] run;
    } ctrl_view_t;

    // Extract the live fields of a control word.
    function automatic ctrl_view_t split_ctrl(input logic [15:0] w);
        ctrl_view_t v;
        v.mode = w[BIT_MODE];
        v.lvl  = w[BIT_LVL0+1:BIT_LVL0];
        v.flg  = w[BIT_FLG0+1:BIT_FLG0];
        v.ien  = w[BIT_IEN0+1:BIT_IEN0];
        v.run  = w[BIT_RUN0+1:BIT_RUN0];
        return v;
    endfunction

endpackage

// File: rtl/ocu_cmp_chan.sv
// Module: one compare channel. Holds the compare register and detects
// entry into equality between the timer count and that register.
// Assumes: count is sampled each clock; a match is reported once per
// continuous stretch of equality while the channel runs.
module ocu_cmp_chan #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] count,
    input  logic          run,
    input  logic          cmp_we,
    input  logic [TW-1:0] cmp_wdata,
    output logic [TW-1:0] cmp_q,
    output logic          hit
);

    logic eq_now;
    logic eq_seen;

    // Equality while running.
    assign eq_now = run && (count == cmp_q);
    // A hit is the first cycle of an equality stretch.
    assign hit    = eq_now && !eq_seen;

    // Compare register storage.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmp_q <= '0;
        else if (cmp_we) cmp_q <= cmp_wdata;
    end

    // Remember whether equality already held last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) eq_seen <= 1'b0;
        else        eq_seen <= eq_now;
    end

    AST_ONE_HIT_PER_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit); // R12

    AST_HELD_COUNT_NO_REHIT: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !cmp_we) ##1 ($stable(count) && run) |-> !hit); // R12

endmodule

// File: rtl/ocu_ctrl_reg.sv
// Module: control word storage. Holds mode, enables, start bits and the
// match flags; builds the control read word and the interrupt lines.
// Assumes: wr_ctrl is a single-cycle strobe; pin levels arrive from the
// pin driver for readback.
module ocu_ctrl_reg
    import ocu_pair_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_ctrl,
    input  logic [15:0] wdata,
    input  logic        rmw,
    input  logic [1:0]  hit,
    input  logic [1:0]  pin_lvl,
    output logic        mode,
    output logic [1:0]  run,
    output logic [1:0]  flag,
    output logic [1:0]  irq,
    output logic [15:0] ctrl_rdata
);

    ctrl_view_t wv;
    logic [1:0] ien;
    logic [1:0] flag_rd;

    assign wv = split_ctrl(wdata);

    // Mode, enables and start bits load on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= 1'b0;
            ien  <= 2'b00;
            run  <= 2'b00;
        end else if (wr_ctrl) begin
            mode <= wv.mode;
            ien  <= wv.ien;
            run  <= wv.run;
        end
    end

    // Flags: set by a hit, cleared by writing 0; a hit wins.
    generate
        for (genvar i = 0; i < NCH; i++) begin : g_flag
            always_ff @(posedge clk) begin
                if (!rst_n)                     flag[i] <= 1'b0;
                else if (hit[i])                flag[i] <= 1'b1;
                else if (wr_ctrl && !wv.flg[i]) flag[i] <= 1'b0;
            end

            AST_HIT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
                hit[i] |=> flag[i]); // R4

            AST_FLAG_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(flag[i]) |-> $past(hit[i])); // R5

            AST_ONE_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_ctrl && wv.flg[i]) |=> !$fell(flag[i])); // R9
        end
    endgenerate

    // Interrupt request per channel.
    assign irq = flag & ien;

    // Flags read as ones during a read-modify-write.
    assign flag_rd = rmw ? 2'b11 : flag;

    // Assemble the control read word.
    always_comb begin
        ctrl_rdata = FIXED_ONES;
        ctrl_rdata[BIT_MODE]              = mode;
        ctrl_rdata[BIT_LVL0+1:BIT_LVL0]   = pin_lvl;
        ctrl_rdata[BIT_FLG0+1:BIT_FLG0]   = flag_rd;
        ctrl_rdata[BIT_IEN0+1:BIT_IEN0]   = ien;
        ctrl_rdata[BIT_RUN0+1:BIT_RUN0]   = run;
    end

endmodule

// File: rtl/ocu_pin_drv.sv
// Module: output pin driver. Routes channel hits to pin toggles by mode
// and applies direct level writes, which take priority over toggles.
// Assumes: hit pulses last one cycle.
module ocu_pin_drv
    import ocu_pair_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode,
    input  logic [1:0] hit,
    input  logic       lvl_we,
    input  logic [1:0] lvl_wdata,
    output logic [1:0] pin
);

    logic [1:0] flip;

    // Pin 0 follows channel 0; pin 1 also follows channel 0 in paired mode.
    assign flip[0] = hit[0];
    assign flip[1] = hit[1] | (mode & hit[0]);

    // Pin registers: level write first, otherwise toggle.
    always_ff @(posedge clk) begin
        if (!rst_n)      pin <= 2'b00;
        else if (lvl_we) pin <= lvl_wdata;
        else             pin <= pin ^ flip;
    end

    AST_PIN_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl_we && hit == 2'b00) |=> $stable(pin)); // R5

    AST_SEP_PIN1_OWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl_we && !mode && !hit[1]) |=> $stable(pin[1])); // R6

    AST_PIN0_CH0_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl_we && !hit[0]) |=> $stable(pin[0])); // R7

    AST_PAIR_PIN1_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl_we && mode && hit[0]) |=> (pin[1] != $past(pin[1]))); // R7

    AST_LEVEL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_we |=> (pin == $past(lvl_wdata))); // R8

endmodule

// File: rtl/ocu_pair.sv
// Module: paired output compare unit top. Decodes the register bus,
// instantiates two compare channels, the control word and the pin driver,
// and muxes read data.
// Assumes: the bus is a single-cycle access with combinational read data;
// the timer count is synchronous to clk.
module ocu_pair
    import ocu_pair_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] tmr_count,
    input  logic          bus_sel,
    input  logic          bus_we,
    input  logic          bus_rmw,
    input  logic [1:0]    bus_addr,
    input  logic [15:0]   bus_wdata,
    output logic [15:0]   bus_rdata,
    output logic [1:0]    irq,
    output logic [1:0]    pin_out
);

    localparam int CW = (TW < 16) ? TW : 16;

    logic          wr_any;
    logic          wr_ctrl;
    logic [1:0]    hit;
    logic [1:0]    run;
    logic [1:0]    flag;
    logic          mode;
    logic [15:0]   ctrl_rdata;
    logic [TW-1:0] cmp_q [NCH];
    logic [TW-1:0] cmp_wdata;
    ctrl_view_t    wv;

    assign wr_any  = bus_sel && bus_we;
    assign wr_ctrl = wr_any && (bus_addr == ADDR_CTRL);
    assign wv      = split_ctrl(bus_wdata);

    // Widen or narrow bus data to the compare width.
    always_comb begin
        cmp_wdata = '0;
        cmp_wdata[CW-1:0] = bus_wdata[CW-1:0];
    end

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_chan
            logic cmp_we;
            assign cmp_we = wr_any && (bus_addr == ADDR_CMP0 + 2'(i));

            ocu_cmp_chan #(.TW(TW)) u_chan (
                .clk       (clk),
                .rst_n     (rst_n),
                .count     (tmr_count),
                .run       (run[i]),
                .cmp_we    (cmp_we),
                .cmp_wdata (cmp_wdata),
                .cmp_q     (cmp_q[i]),
                .hit       (hit[i])
            );
        end
    endgenerate

    ocu_ctrl_reg u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ctrl    (wr_ctrl),
        .wdata      (bus_wdata),
        .rmw        (bus_rmw),
        .hit        (hit),
        .pin_lvl    (pin_out),
        .mode       (mode),
        .run        (run),
        .flag       (flag),
        .irq        (irq),
        .ctrl_rdata (ctrl_rdata)
    );

    ocu_pin_drv u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .hit       (hit),
        .lvl_we    (wr_ctrl),
        .lvl_wdata (wv.lvl),
        .pin       (pin_out)
    );

    // Read data select by address.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            case (bus_addr)
                ADDR_CTRL:     bus_rdata = ctrl_rdata;
                ADDR_CMP0:     bus_rdata[CW-1:0] = cmp_q[0][CW-1:0];
                ADDR_CMP0 + 1: bus_rdata[CW-1:0] = cmp_q[1][CW-1:0];
                default:       bus_rdata = '0;
            endcase
        end
    end

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq[0]) |-> flag[0]); // R11

    AST_STOPPED_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (!run[1] && !flag[1]) |=> !flag[1]); // R5

endmodule

// File: tb/ocu_pair_test.sv
`timescale 1ns/1ps
// Bench: behavioural reference model of the paired compare unit, compared
// against the design's pins, interrupt lines and read data on every clock.
module ocu_pair_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] tmr_count = 16'h5555;
    logic        bus_sel = 1'b1;
    logic        bus_we = 1'b0;
    logic        bus_rmw = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'h0000;
    logic [15:0] bus_rdata;
    logic [1:0]  irq;
    logic [1:0]  pin_out;

    ocu_pair uut (
        .clk(clk), .rst_n(rst_n), .tmr_count(tmr_count),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_rmw(bus_rmw),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .pin_out(pin_out)
    );

    always #2.5 clk = ~clk;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // Reference state.
    int m_cmp [2];
    bit m_mode;
    bit m_pin [2];
    bit m_flag [2];
    bit m_ien [2];
    bit m_run [2];
    bit m_inside [2];

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    function automatic logic [15:0] exp_rdata();
        logic [15:0] r;
        r = 16'h0000;
        if (bus_sel) begin
            case (bus_addr)
                2'd0: begin
                    r = 16'hEC0C;
                    r[12] = m_mode;
                    r[9] = m_pin[1];   r[8] = m_pin[0];
                    r[7] = bus_rmw ? 1'b1 : m_flag[1];
                    r[6] = bus_rmw ? 1'b1 : m_flag[0];
                    r[5] = m_ien[1];   r[4] = m_ien[0];
                    r[1] = m_run[1];   r[0] = m_run[0];
                end
                2'd1: r = 16'(m_cmp[0]);
                2'd2: r = 16'(m_cmp[1]);
                default: r = 16'h0000;
            endcase
        end
        return r;
    endfunction

    task automatic model_edge();
        bit h [2];
        bit wc;
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_cmp[i] = 0; m_pin[i] = 0; m_flag[i] = 0;
                m_ien[i] = 0; m_run[i] = 0; m_inside[i] = 0;
            end
            m_mode = 0;
            return;
        end
        for (int i = 0; i < 2; i++) begin
            bit now_eq;
            now_eq = m_run[i] && (int'(tmr_count) == m_cmp[i]);
            h[i] = now_eq && !m_inside[i];
            m_inside[i] = now_eq;
        end
        wc = bus_sel && bus_we && (bus_addr == 2'd0);
        if (wc) begin
            m_pin[0] = bus_wdata[8];
            m_pin[1] = bus_wdata[9];
        end else begin
            if (h[0]) m_pin[0] = !m_pin[0];
            if (h[1] || (m_mode && h[0])) m_pin[1] = !m_pin[1];
        end
        for (int i = 0; i < 2; i++) begin
            if (h[i]) m_flag[i] = 1;
            else if (wc && !bus_wdata[6+i]) m_flag[i] = 0;
        end
        if (wc) begin
            m_mode = bus_wdata[12];
            m_ien[0] = bus_wdata[4]; m_ien[1] = bus_wdata[5];
            m_run[0] = bus_wdata[0]; m_run[1] = bus_wdata[1];
        end
        if (bus_sel && bus_we && bus_addr == 2'd1) m_cmp[0] = int'(bus_wdata);
        if (bus_sel && bus_we && bus_addr == 2'd2) m_cmp[1] = int'(bus_wdata);
    endtask

    task automatic compare_all();
        check(cur_req, {14'd0, pin_out}, {14'd0, m_pin[1], m_pin[0]});
        check(cur_req, {14'd0, irq},
              {14'd0, m_flag[1] & m_ien[1], m_flag[0] & m_ien[0]});
        check(cur_req, bus_rdata, exp_rdata());
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_we = 1'b0; bus_addr = 2'd0;
    endtask

    task automatic rd(input logic [1:0] a);
        bus_addr = a;
        #1;
    endtask

    // Control word with flag bits written as 1 (no clear).
    function automatic logic [15:0] cw(input bit md, input logic [1:0] lv,
                                       input logic [1:0] ie, input logic [1:0] rn);
        return {3'b111, md, 2'b11, lv, 2'b11, ie, 2'b11, rn};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        cur_req = "R1";
        repeat (3) tick();
        rst_n = 1'b1;
        rd(2'd0);
        check("R1", bus_rdata, 16'hEC0C);
        check("R1", {14'd0, pin_out}, 16'h0000);
        check("R1", {14'd0, irq}, 16'h0000);
        rd(2'd1); check("R1", bus_rdata, 16'h0000);
        rd(2'd0);

        cur_req = "R2";
        wr(2'd0, 16'h0000);
        rd(2'd0); check("R2", bus_rdata, 16'hEC0C);
        wr(2'd0, 16'hFFFF);
        rd(2'd0); check("R2", bus_rdata, 16'hFF3F);
        wr(2'd0, 16'h0000);

        cur_req = "R3";
        wr(2'd1, 16'h1234);
        wr(2'd2, 16'hBEEF);
        rd(2'd1); check("R3", bus_rdata, 16'h1234);
        rd(2'd2); check("R3", bus_rdata, 16'hBEEF);
        rd(2'd3); check("R3", bus_rdata, 16'h0000);
        bus_sel = 1'b0; #1; check("R3", bus_rdata, 16'h0000);
        bus_sel = 1'b1; rd(2'd0);

        cur_req = "R4";
        wr(2'd0, cw(0, 2'b00, 2'b11, 2'b11));
        tmr_count = 16'h1234; tick();
        check("R4", {14'd0, pin_out}, 16'h0001);
        check("R11", {14'd0, irq}, 16'h0001);
        cur_req = "R12";
        repeat (4) tick();
        check("R12", {14'd0, pin_out}, 16'h0001);
        cur_req = "R6";
        tmr_count = 16'hBEEF; tick();
        check("R6", {14'd0, pin_out}, 16'h0003);
        check("R11", {14'd0, irq}, 16'h0003);

        cur_req = "R9";
        wr(2'd0, 16'h0033);
        check("R9", {14'd0, bus_rdata[7:6]}, 16'h0000);
        check("R11", {14'd0, irq}, 16'h0000);
        cur_req = "R10";
        bus_rmw = 1'b1; #1;
        check("R10", {14'd0, bus_rdata[7:6]}, 16'h0003);
        bus_rmw = 1'b0; #1;

        cur_req = "R9";
        tmr_count = 16'h5555; tick();
        tmr_count = 16'h1234; tick();
        wr(2'd0, cw(0, 2'b01, 2'b11, 2'b11));
        check("R9", {15'd0, bus_rdata[6]}, 16'h0001);

        cur_req = "R5";
        wr(2'd0, cw(0, 2'b01, 2'b11, 2'b00));
        tmr_count = 16'h5555; tick();
        tmr_count = 16'hBEEF; tick();
        tmr_count = 16'h1234; tick();
        check("R5", {14'd0, pin_out}, 16'h0001);
        check("R5", {15'd0, bus_rdata[7]}, 16'h0000);

        cur_req = "R7";
        tmr_count = 16'h5555;
        wr(2'd0, cw(1, 2'b00, 2'b11, 2'b11));
        tmr_count = 16'h1234; tick();
        check("R7", {14'd0, pin_out}, 16'h0003);
        tmr_count = 16'h5555;
        wr(2'd2, 16'h1234);
        tmr_count = 16'h1234; tick();
        check("R7", {14'd0, pin_out}, 16'h0000);

        cur_req = "R8";
        tmr_count = 16'h5555; tick();
        tmr_count = 16'h1234;
        wr(2'd0, cw(1, 2'b10, 2'b11, 2'b11));
        check("R8", {14'd0, pin_out}, 16'h0002);

        cur_req = "R9";
        tmr_count = 16'h5555; tick();
        tmr_count = 16'h1234;
        wr(2'd0, 16'h1033);
        check("R9", {14'd0, bus_rdata[7:6]}, 16'h0003);

        cur_req = "R12";
        wr(2'd2, 16'hBEEF);
        for (int n = 0; n < 4000; n++) begin
            int r;
            r = int'($urandom_range(0, 9));
            if (r < 2)       tmr_count = 16'h1234;
            else if (r < 4)  tmr_count = 16'hBEEF;
            else if (r < 6)  tmr_count = 16'($urandom_range(0, 3));
            else if (r < 8)  tmr_count = tmr_count;
            else             tmr_count = 16'h5555;
            bus_rmw = ($urandom_range(0, 7) == 0);
            if ($urandom_range(0, 9) == 0) begin
                logic [1:0] a;
                logic [15:0] d;
                a = 2'($urandom_range(0, 3));
                d = 16'($urandom);
                if (a != 2'd0) d = 16'($urandom_range(0, 3)) | (d & 16'h1234);
                wr(a, d);
            end else begin
                bus_addr = 2'($urandom_range(0, 3));
                tick();
            end
        end
        bus_rmw = 1'b0;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule